// File: doc/BRIEF.md
# Octet-configured logic cell

This block models one fine-grained programmable logic cell. Its whole function is held in a few configuration octets, and those octets are written through a narrow port. Each write carries a type octet, which picks the target, and a data octet, which holds the value. The cell has the following parts:

- two 3-input lookup tables, X and Y, that share one index;
- a selector for the third table input;
- a selector for the register input;
- one register with a programmable asynchronous set-or-reset action;
- steering that places either the table results or the cell's center signal on the two neighbour outputs.

The lookup tables are stored in inverted form. Each selector falls back to a default source when all of its select bits are low. Because of this, an all-zero configuration yields a defined cell: both outputs read 1.

The block sits inside a fabric model. A loader writes the octets after reset. The surrounding routing then drives the X, Y, W and Z inputs and the set/reset strobe, and reads the two neighbour outputs.

Top module: `cfg_logic_cell`

## Requirements
- R1: A write (`cfg_we` high at a rising clock edge) is accepted only when `cfg_type[7:4]` is 0000. A write with any other upper nibble leaves every configuration octet unchanged. Within an accepted write, the low nibble selects the target: 0001 is the control octet, 0010 is the mode octet, 0110 is the X table and 0111 is the Y table. Other low nibbles change nothing.
- R2: The table octets hold the inverted truth table. The table index is {W', Y, X}, where W' is the selected third input in bit 2 and `in_x` is bit 0. Each table output is the complement of its stored bit at that index.
- R3: The third table input W' is selected by two control-octet bits. With bit 5 set, W' is `in_w & in_z`. Otherwise, with bit 4 set, W' is the feedback line. With neither bit set, W' is `in_w`. Bit 5 has priority over bit 4.
- R4: The register loads at the rising clock edge, and its input is selected by two control-octet bits. With bit 7 set, it loads `in_z`. Otherwise, with bit 6 set, it loads the Y-table output. With neither bit set, it loads the X-table output. Bit 7 has priority over bit 6.
- R5: Control bit 3 set makes the center signal `in_z`; clear makes it the register. Control bit 2 set makes the feedback line `in_z`; clear makes it the register. Both take effect without a clock edge.
- R6: While `sr` is high, the register is forced at once, without waiting for a clock edge. The forced value depends on mode-octet bit 0: 0 forces 1 (set) and 1 forces 0 (reset).
- R7: Control bit 1 set drives `out_x` from the center signal; clear drives it from the X table. Control bit 0 set drives `out_y` from the center signal; clear drives it from the Y table.
- R8: `rst_n` low clears every configuration octet and the register, asynchronously. As a result, both outputs read 1 for any input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_type | input | 8 | Type octet of a configuration write |
| cfg_data | input | 8 | Data octet of a configuration write |
| in_x | input | 1 | Cell input X, table index bit 0 |
| in_y | input | 1 | Cell input Y, table index bit 1 |
| in_w | input | 1 | Cell input W, default third table input |
| in_z | input | 1 | Cell input Z |
| sr | input | 1 | Asynchronous set/reset strobe, active high |
| out_x | output | 1 | X neighbour output |
| out_y | output | 1 | Y neighbour output |

## Verification
The assertions check four things on every cycle:

- writes with a non-zero upper type nibble never disturb the configuration;
- a table write lands exactly as given;
- the register follows its selected input edge to edge;
- a high strobe holds the register at the level chosen by the mode bit, and an enabled X steering path copies the register when the bypass is off.

The source priorities inside the two selectors, the inverted table lookup over all eight index values, the combinational bypass paths and the outputs after a mid-run reset can only be shown by the bench's scenarios. Those scenarios drive chosen input patterns and compare the neighbour outputs against hand-derived values.

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_type,
  input  logic [7:0] cfg_data,
  input  logic       in_x,
  input  logic       in_y,
  input  logic       in_w,
  input  logic       in_z,
  input  logic       sr,
  output logic       out_x,
  output logic       out_y
);
  localparam int LUT_IN = 3;
  localparam int LUT_SZ = 1 << LUT_IN;
  localparam logic [3:0] T_CTRL = 4'h1;
  localparam logic [3:0] T_MODE = 4'h2;
  localparam logic [3:0] T_XLUT = 4'h6;
  localparam logic [3:0] T_YLUT = 4'h7;

  logic [7:0]        ctrl;
  logic [LUT_SZ-1:0] xtab, ytab;
  logic              sr_rst;
  logic              q;

  wire cell_wr = cfg_we && (cfg_type[7:4] == 4'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      xtab   <= '0;
      ytab   <= '0;
      sr_rst <= 1'b0;
    end else if (cell_wr) begin
      case (cfg_type[3:0])
        T_CTRL:  ctrl   <= cfg_data;
        T_MODE:  sr_rst <= cfg_data[0];
        T_XLUT:  xtab   <= cfg_data[LUT_SZ-1:0];
        T_YLUT:  ytab   <= cfg_data[LUT_SZ-1:0];
        default: ;
      endcase
    end
  end

  logic zm_r, yl_r, wz_w, fb_w, byp_c, byp_fb, c_xo, c_yo;
  assign {zm_r, yl_r, wz_w, fb_w, byp_c, byp_fb, c_xo, c_yo} = ctrl;

  logic              fb, w_eff, xl, yl, d_sel, center;
  logic [LUT_IN-1:0] idx;

  assign fb     = byp_fb ? in_z : q;
  assign w_eff  = wz_w ? (in_w & in_z) : (fb_w ? fb : in_w);
  assign idx    = {w_eff, in_y, in_x};
  assign xl     = ~xtab[idx];
  assign yl     = ~ytab[idx];
  assign d_sel  = zm_r ? in_z : (yl_r ? yl : xl);
  assign center = byp_c ? in_z : q;

  always_ff @(posedge clk or negedge rst_n or posedge sr) begin
    if (!rst_n)  q <= 1'b0;
    else if (sr) q <= ~sr_rst;
    else         q <= d_sel;
  end

  assign out_x = c_xo ? center : xl;
  assign out_y = c_yo ? center : yl;

  AST_FOREIGN_TYPE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_type[7:4] != 4'h0) |=> ($stable(ctrl) && $stable(xtab) && $stable(ytab) && $stable(sr_rst))); // R1
  AST_XTAB_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && cfg_type == 8'h06) |=> (xtab == $past(cfg_data[LUT_SZ-1:0]))); // R2
  AST_REG_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n || sr) !sr |=> (q == $past(d_sel))); // R4
  AST_STROBE_FORCES: assert property (@(posedge clk) disable iff (!rst_n) sr |-> (q == ~sr_rst)); // R6
  AST_XO_FROM_REG: assert property (@(posedge clk) disable iff (!rst_n) (c_xo && !byp_c) |-> (out_x == q)); // R7
endmodule

// File: tb/cfg_logic_cell_test.sv
module cfg_logic_cell_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_type = '0;
  logic [7:0] cfg_data = '0;
  logic in_x = 0, in_y = 0, in_w = 0, in_z = 0, sr = 0;
  logic out_x, out_y;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_logic_cell uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_type(cfg_type), .cfg_data(cfg_data),
    .in_x(in_x), .in_y(in_y), .in_w(in_w), .in_z(in_z), .sr(sr),
    .out_x(out_x), .out_y(out_y)
  );

  localparam logic [7:0] XT = 8'hB4;
  localparam logic [7:0] YT = 8'h3C;
  localparam int NV = 18;
  // {ctrl, x, y, w, z, expected out_x, expected out_y}
  localparam logic [13:0] VEC [NV] = '{
    {8'h00, 4'b0000, 2'b11}, {8'h00, 4'b1000, 2'b11},
    {8'h00, 4'b0100, 2'b00}, {8'h00, 4'b1100, 2'b10},
    {8'h00, 4'b0010, 2'b00}, {8'h00, 4'b1011, 2'b00},
    {8'h00, 4'b0110, 2'b11}, {8'h00, 4'b1111, 2'b01},
    {8'h20, 4'b0110, 2'b00}, {8'h20, 4'b0111, 2'b11},
    {8'h30, 4'b1110, 2'b10}, {8'h20, 4'b1001, 2'b11},
    {8'h0A, 4'b0101, 2'b10}, {8'h0A, 4'b0100, 2'b00},
    {8'h09, 4'b1100, 2'b10}, {8'h09, 4'b1101, 2'b11},
    {8'h14, 4'b0001, 2'b00}, {8'h14, 4'b1110, 2'b10}
  };

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] t, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_type = t; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pins(input logic x, input logic y, input logic w, input logic z);
    in_x = x; in_y = y; in_w = w; in_z = z;
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] cur;
    // R8: reset state
    pins(0, 1, 0, 0);
    #2;
    check(out_x, 1'b1, "R8 out_x in reset");
    check(out_y, 1'b1, "R8 out_y in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    wr(8'h06, XT);
    wr(8'h07, YT);
    cur = 8'h00;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][13:6] != cur) begin
        cur = VEC[i][13:6];
        wr(8'h01, cur);
      end
      @(negedge clk);
      pins(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      #1;
      check(out_x, VEC[i][1], $sformatf("vector %0d out_x (R2, R3, R5, R7)", i));
      check(out_y, VEC[i][0], $sformatf("vector %0d out_y (R2, R3, R5, R7)", i));
    end

    // R1: writes with a non-zero upper nibble are ignored
    wr(8'h01, 8'h00);
    wr(8'h16, 8'h00);
    wr(8'h17, 8'h00);
    wr(8'hF1, 8'h02);
    wr(8'h03, 8'hFF);
    @(negedge clk);
    pins(0, 1, 0, 0);
    #1;
    check(out_x, 1'b0, "R1 foreign writes, out_x");
    check(out_y, 1'b0, "R1 foreign writes, out_y");

    // R4: register loads Z on the edge, not before
    wr(8'h01, 8'h82);
    pins(0, 0, 0, 1);
    edge_then_sample();
    check(out_x, 1'b1, "R4 Z source loaded");
    @(negedge clk);
    in_z = 0;
    #1;
    check(out_x, 1'b1, "R4 register holds before edge");
    edge_then_sample();
    check(out_x, 1'b0, "R4 Z source after edge");

    // R4: Z wins over Y table
    wr(8'h01, 8'hC2);
    pins(0, 1, 0, 1);
    edge_then_sample();
    check(out_x, 1'b1, "R4 Z priority over Y table");
    wr(8'h01, 8'h42);
    pins(0, 1, 0, 1);
    edge_then_sample();
    check(out_x, 1'b0, "R4 Y table source");
    wr(8'h01, 8'h02);
    pins(1, 1, 0, 0);
    edge_then_sample();
    check(out_x, 1'b1, "R4 X table default source");

    // R3: feedback from register as third input, out_y shows the register
    wr(8'h01, 8'h91);
    pins(0, 0, 0, 1);
    edge_then_sample();
    check(out_y, 1'b1, "R5 center is register");
    check(out_x, 1'b0, "R3 feedback as third input, high");
    @(negedge clk);
    in_z = 0;
    edge_then_sample();
    check(out_x, 1'b1, "R3 feedback as third input, low");

    // R6: asynchronous set
    wr(8'h02, 8'h00);
    wr(8'h01, 8'h82);
    pins(0, 0, 0, 0);
    edge_then_sample();
    check(out_x, 1'b0, "R6 register cleared before set");
    @(negedge clk);
    sr = 1;
    #1;
    check(out_x, 1'b1, "R6 set acts without edge");
    edge_then_sample();
    check(out_x, 1'b1, "R6 set held across edge");
    @(negedge clk);
    sr = 0;
    edge_then_sample();
    check(out_x, 1'b0, "R6 register resumes after set");

    // R6: asynchronous reset
    wr(8'h02, 8'h01);
    in_z = 1;
    edge_then_sample();
    check(out_x, 1'b1, "R6 register high before reset");
    @(negedge clk);
    sr = 1;
    #1;
    check(out_x, 1'b0, "R6 reset acts without edge");
    @(negedge clk);
    sr = 0;

    // R8: mid-run reset clears configuration
    wr(8'h01, 8'h00);
    pins(0, 1, 0, 0);
    #1;
    check(out_y, 1'b0, "R8 programmed value before reset");
    @(negedge clk);
    rst_n = 0;
    #1;
    check(out_x, 1'b1, "R8 out_x after mid-run reset");
    check(out_y, 1'b1, "R8 out_y after mid-run reset");
    @(negedge clk);
    rst_n = 1;
    pins(1, 1, 1, 1);
    #1;
    check(out_x, 1'b1, "R8 table cleared, out_x");
    check(out_y, 1'b1, "R8 table cleared, out_y");

    finish_run();
  end
endmodule